// File: doc/BRIEF.md
# Nesting Priority Interrupt Controller

This block sits beside an 8-bit microcontroller core. It collects eleven interrupt sources and resolves them into forced subroutine calls. The source pins are sampled on a machine-cycle strobe into request flags. Each flag is gated by a per-source enable bit and a master enable. Among the survivors the block picks one by programmable level, and at the next instruction boundary it pulses an acknowledge carrying that source's vector address. The core then performs a long call to that address.

The controller remembers which of the four priority levels are in service. A new request can only break into a running handler when its level is strictly above every level already active. When the core reports that the finishing instruction is a return-from-interrupt, the topmost active level is released. For one boundary after such a return, or after any write to the enable or level registers, no acknowledge is issued. This gives software one instruction to act before a new interrupt can arrive.

Top module: `intc_top`

## Requirements
- R1: A source's request flag latches when its condition is sampled, even while that source or the master enable is off; enabling it later leads to an acknowledge without a new event.
- R2: Source pins are only looked at on cycles where `mc_stb_i` is high; a source that rises and is never strobed raises no request.
- R3: With the master enable (register 0 bit 7) clear, no acknowledge is issued.
- R4: Per-source enables: register 0 bits 0..4 enable sources 0..4, register 2 bit 0 enables source 5, register 1 bits 1..5 enable sources 6..10; a disabled source is never acknowledged.
- R5: An acknowledge is issued only at a cycle with `instr_end_i` high; `ack_o` pulses for exactly the following cycle with `vec_o` = 0x0003 + 8 × source index and `ack_src_o` = source index.
- R6: Among pending enabled requests, the highest level wins; on equal level, the lowest source index wins.
- R7: A request is acknowledged only when its level is strictly above every level currently in service, so equal or lower levels never nest.
- R8: A boundary with `instr_reti_i` high releases only the highest level in service; lower active levels stay in service.
- R9: No acknowledge is issued at a boundary whose instruction is a return-from-interrupt, nor at the first boundary following a register write (including a write in the boundary cycle itself).
- R10: Sources 0, 2 and 6..10 are edge sources: the flag sets on a sampled 0→1 change and clears when that source is acknowledged. Sources 1 and 3..5 are level sources: the flag follows the last sample.
- R11: Source i uses group g = i mod 6, and its level is {register 4 bit g, register 3 bit g} (0 lowest, 3 highest).
- R12: Registers reset to 0 and read back the written value masked to implemented bits: register 0 mask 0x9F, register 1 0x3E, register 2 0x01, registers 3 and 4 0x3F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address (0..4) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| src_i | input | 11 | Interrupt source pins |
| mc_stb_i | input | 1 | Machine-cycle sample strobe |
| instr_end_i | input | 1 | The current instruction completes this cycle |
| instr_reti_i | input | 1 | The completing instruction is a return-from-interrupt |
| ack_o | output | 1 | One-cycle acknowledge / forced-call request |
| vec_o | output | 16 | Vector address of the acknowledged source |
| ack_src_o | output | 4 | Index of the acknowledged source |

## Verification
The bench uses the default parameters: vector base 0x0003, step 8, and an edge mask of 0x7C5. That mask mixes edge and level sources, so it exercises both ways a flag can clear: a latched edge that survives the source dropping, and a level flag that vanishes without ever being acknowledged. The four levels and the modulo-6 grouping allow two-deep nesting. They also allow a same-level tie between sources 1 and 7, which share a group.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int NSRC = 11;
    localparam int IDXW = $clog2(NSRC);
    localparam int NLVL = 4;
    localparam int LVLW = $clog2(NLVL);
    localparam int NGRP = 6;
    localparam int AW   = 3;

    localparam logic [7:0] EN0_MASK = 8'h9F;
    localparam logic [7:0] EN1_MASK = 8'h3E;
    localparam logic [7:0] EN2_MASK = 8'h01;
    localparam logic [7:0] PRI_MASK = 8'h3F;

    typedef enum logic [AW-1:0] {
        A_EN0    = 3'd0,
        A_EN1    = 3'd1,
        A_EN2    = 3'd2,
        A_PRI_LO = 3'd3,
        A_PRI_HI = 3'd4
    } reg_addr_e;

    typedef logic [LVLW-1:0] lvl_t;
endpackage

// File: rtl/intc_flags.sv
module intc_flags
    import intc_pkg::*;
#(
    parameter logic [NSRC-1:0] EDGE_MASK = 11'h7C5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stb_i,
    input  logic [NSRC-1:0] src_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] flag_o
);
    typedef struct packed {
        logic [NSRC-1:0] samp;
        logic [NSRC-1:0] flag;
    } fl_st_t;

    fl_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        st_d.flag = st_q.flag & ~(clr_i & EDGE_MASK);
        if (stb_i) begin
            st_d.samp = src_i;
            for (int i = 0; i < NSRC; i++) begin
                if (EDGE_MASK[i]) st_d.flag[i] = st_d.flag[i] | (src_i[i] & ~st_q.samp[i]);
                else              st_d.flag[i] = src_i[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!stb_i && clr_i == '0) |=> $stable(flag_o));

    for (genvar g = 0; g < NSRC; g++) begin : g_chk
        if (EDGE_MASK[g]) begin : g_edge
            p_edge_latch_r1: assert property (@(posedge clk) disable iff (!rst_n)
                (stb_i && src_i[g] && !st_q.samp[g]) |=> flag_o[g]);
        end else begin : g_level
            p_level_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
                stb_i |=> (flag_o[g] == $past(src_i[g])));
        end
    end
endmodule

// File: rtl/intc_arb.sv
module intc_arb
    import intc_pkg::*;
(
    input  logic [NSRC-1:0]           req_i,
    input  logic [NSRC-1:0][LVLW-1:0] lvl_i,
    input  logic [NLVL-1:0]           isr_i,
    output logic                      vld_o,
    output logic [IDXW-1:0]           idx_o,
    output lvl_t                      lvl_o
);
    logic            found;
    logic            busy;
    lvl_t            top_lvl;
    lvl_t            best_lvl;
    logic [IDXW-1:0] best_idx;

    always_comb begin
        found    = 1'b0;
        best_lvl = '0;
        best_idx = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (req_i[i] && (!found || lvl_i[i] > best_lvl)) begin
                found    = 1'b1;
                best_lvl = lvl_i[i];
                best_idx = IDXW'(i);
            end
        end
        busy    = 1'b0;
        top_lvl = '0;
        for (int l = 0; l < NLVL; l++) begin
            if (isr_i[l]) begin
                busy    = 1'b1;
                top_lvl = LVLW'(l);
            end
        end
        vld_o = found && (!busy || best_lvl > top_lvl);
        idx_o = best_idx;
        lvl_o = best_lvl;
    end
endmodule

// File: rtl/intc_top.sv
module intc_top
    import intc_pkg::*;
#(
    parameter int                VECW      = 16,
    parameter int                VEC_BASE  = 3,
    parameter int                VEC_STEP  = 8,
    parameter logic [NSRC-1:0]   EDGE_MASK = 11'h7C5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [7:0]       wdata_i,
    output logic [7:0]       rdata_o,
    input  logic [NSRC-1:0]  src_i,
    input  logic             mc_stb_i,
    input  logic             instr_end_i,
    input  logic             instr_reti_i,
    output logic             ack_o,
    output logic [VECW-1:0]  vec_o,
    output logic [IDXW-1:0]  ack_src_o
);
    typedef struct packed {
        logic [7:0]      en0;
        logic [7:0]      en1;
        logic [7:0]      en2;
        logic [7:0]      plo;
        logic [7:0]      phi;
        logic [NLVL-1:0] isr;
        logic            cfg_pend;
        logic            ack;
        logic [VECW-1:0] vec;
        logic [IDXW-1:0] asrc;
    } ctl_st_t;

    ctl_st_t cur_q, nxt_d;

    logic [NSRC-1:0]           flag;
    logic [NSRC-1:0]           en_vec;
    logic [NSRC-1:0]           clr_d;
    logic [NSRC-1:0][LVLW-1:0] src_lvl;
    logic                      g_vld;
    logic [IDXW-1:0]           g_idx;
    lvl_t                      g_lvl;
    logic                      blocked;

    intc_flags #(.EDGE_MASK(EDGE_MASK)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb_i  (mc_stb_i),
        .src_i  (src_i),
        .clr_i  (clr_d),
        .flag_o (flag)
    );

    assign en_vec = {cur_q.en1[5:1], cur_q.en2[0], cur_q.en0[4:0]};

    for (genvar s = 0; s < NSRC; s++) begin : g_lvl_map
        localparam int GRP = s % NGRP;
        assign src_lvl[s] = {cur_q.phi[GRP], cur_q.plo[GRP]};
    end

    intc_arb u_arb (
        .req_i (flag & en_vec & {NSRC{cur_q.en0[7]}}),
        .lvl_i (src_lvl),
        .isr_i (cur_q.isr),
        .vld_o (g_vld),
        .idx_o (g_idx),
        .lvl_o (g_lvl)
    );

    assign blocked = instr_reti_i || cur_q.cfg_pend || wr_en_i;

    always_comb begin
        int top;
        nxt_d = cur_q;
        nxt_d.ack = 1'b0;
        clr_d = '0;
        top = -1;
        if (wr_en_i) begin
            nxt_d.cfg_pend = 1'b1;
            case (reg_addr_e'(addr_i))
                A_EN0:    nxt_d.en0 = wdata_i & EN0_MASK;
                A_EN1:    nxt_d.en1 = wdata_i & EN1_MASK;
                A_EN2:    nxt_d.en2 = wdata_i & EN2_MASK;
                A_PRI_LO: nxt_d.plo = wdata_i & PRI_MASK;
                A_PRI_HI: nxt_d.phi = wdata_i & PRI_MASK;
                default:  ;
            endcase
        end
        if (instr_end_i) begin
            nxt_d.cfg_pend = wr_en_i;
            if (instr_reti_i) begin
                for (int l = 0; l < NLVL; l++) if (cur_q.isr[l]) top = l;
                if (top >= 0) nxt_d.isr[top] = 1'b0;
            end else if (!blocked && g_vld) begin
                nxt_d.ack        = 1'b1;
                nxt_d.asrc       = g_idx;
                nxt_d.vec        = VECW'(VEC_BASE + VEC_STEP * int'(g_idx));
                nxt_d.isr[g_lvl] = 1'b1;
                clr_d[g_idx]     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    always_comb begin
        case (reg_addr_e'(addr_i))
            A_EN0:    rdata_o = cur_q.en0;
            A_EN1:    rdata_o = cur_q.en1;
            A_EN2:    rdata_o = cur_q.en2;
            A_PRI_LO: rdata_o = cur_q.plo;
            A_PRI_HI: rdata_o = cur_q.phi;
            default:  rdata_o = '0;
        endcase
    end

    assign ack_o     = cur_q.ack;
    assign vec_o     = cur_q.vec;
    assign ack_src_o = cur_q.asrc;

    p_ack_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> $past(instr_end_i));
    p_ack_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o || $past(instr_end_i));
    p_master_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> $past(cur_q.en0[7]));
    p_reti_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> !$past(instr_reti_i));
    p_strict_nest_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> (cur_q.isr > 2 * $past(cur_q.isr)));
    p_release_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_end_i && instr_reti_i && cur_q.isr != '0)
        |=> ($countones(cur_q.isr) + 1 == $countones($past(cur_q.isr))));
endmodule

// File: tb/test_intc_top.sv
module test_intc_top;
    import intc_pkg::*;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en_i = 1'b0;
    logic [AW-1:0]    addr_i = '0;
    logic [7:0]       wdata_i = '0;
    logic [7:0]       rdata_o;
    logic [NSRC-1:0]  src_i = '0;
    logic             mc_stb_i = 1'b0;
    logic             instr_end_i = 1'b0;
    logic             instr_reti_i = 1'b0;
    logic             ack_o;
    logic [15:0]      vec_o;
    logic [IDXW-1:0]  ack_src_o;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    intc_top i_intc_top (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .src_i(src_i),
        .mc_stb_i(mc_stb_i), .instr_end_i(instr_end_i),
        .instr_reti_i(instr_reti_i), .ack_o(ack_o), .vec_o(vec_o),
        .ack_src_o(ack_src_o)
    );

    typedef struct packed {
        logic [NSRC-1:0] mask;
        logic [15:0]     vec;
    } vrow_t;

    // all sources enabled, all at level 0; vector = 3 + 8*idx
    localparam vrow_t TBL [9] = '{
        '{11'h001, 16'h0003},
        '{11'h002, 16'h000B},
        '{11'h010, 16'h0023},
        '{11'h020, 16'h002B},
        '{11'h008, 16'h001B},
        '{11'h400, 16'h0053},
        '{11'h03A, 16'h000B},
        '{11'h038, 16'h001B},
        '{11'h100, 16'h0043}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input string req, input logic [AW-1:0] a, input logic [7:0] exp);
        addr_i = a;
        #1;
        chk(req, rdata_o, exp);
    endtask

    task automatic strobe(input logic [NSRC-1:0] v);
        src_i = v; mc_stb_i = 1'b1;
        @(negedge clk);
        mc_stb_i = 1'b0;
    endtask

    task automatic bnd(input logic reti, input logic exp_ack, input logic [15:0] exp_vec,
                       input string req);
        instr_end_i = 1'b1; instr_reti_i = reti;
        @(negedge clk);
        instr_end_i = 1'b0; instr_reti_i = 1'b0;
        chk(req, ack_o, exp_ack);
        if (exp_ack) chk(req, vec_o, exp_vec);
        if (exp_ack) chk(req, ack_src_o, (exp_vec - 16'd3) >> 3);
        @(negedge clk);
        chk(req, ack_o, 1'b0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset values
        chk("R12 reset ack", ack_o, 1'b0);
        for (int a = 0; a < 5; a++) rd("R12 reset reg", AW'(a), 8'h00);

        // R12 masked read-back
        wr(3'd0, 8'hFF); rd("R12 en0", 3'd0, 8'h9F);
        wr(3'd1, 8'hFF); rd("R12 en1", 3'd1, 8'h3E);
        wr(3'd2, 8'hFF); rd("R12 en2", 3'd2, 8'h01);
        wr(3'd3, 8'hFF); rd("R12 pri lo", 3'd3, 8'h3F);
        wr(3'd4, 8'hFF); rd("R12 pri hi", 3'd4, 8'h3F);
        wr(3'd3, 8'h00); wr(3'd4, 8'h00);
        bnd(1'b0, 1'b0, 16'h0, "R9 settle");

        // R5 vector table walk
        for (int k = 0; k < 9; k++) begin
            strobe(TBL[k].mask);
            bnd(1'b0, 1'b1, TBL[k].vec, "R5/R6 table");
            strobe('0);
            bnd(1'b1, 1'b0, 16'h0, "R9 reti boundary");
        end

        // R10 edge flags were cleared by their acknowledges
        bnd(1'b0, 1'b0, 16'h0, "R10 edge cleared");
        // R10 level flag follows the source
        strobe(11'h002); strobe('0);
        bnd(1'b0, 1'b0, 16'h0, "R10 level dropped");

        // R2 no strobe, no sample
        src_i = 11'h002;
        repeat (3) @(negedge clk);
        bnd(1'b0, 1'b0, 16'h0, "R2 unstrobed");
        strobe(11'h002);
        bnd(1'b0, 1'b1, 16'h000B, "R2 strobed");
        strobe('0);
        bnd(1'b1, 1'b0, 16'h0, "R9 reti");

        // R3 master enable off
        wr(3'd0, 8'h1F);
        bnd(1'b0, 1'b0, 16'h0, "R9 settle");
        strobe(11'h002);
        bnd(1'b0, 1'b0, 16'h0, "R3 master off");
        bnd(1'b0, 1'b0, 16'h0, "R3 master off again");
        // R9 write blocks one boundary, then R1 latched flag is served
        wr(3'd0, 8'h9F);
        bnd(1'b0, 1'b0, 16'h0, "R9 after write");
        bnd(1'b0, 1'b1, 16'h000B, "R1 latched while master off");
        strobe('0);
        bnd(1'b1, 1'b0, 16'h0, "R9 reti");

        // R1/R4 edge event while source disabled
        wr(3'd0, 8'h9E);
        bnd(1'b0, 1'b0, 16'h0, "R9 settle");
        strobe(11'h001); strobe('0);
        bnd(1'b0, 1'b0, 16'h0, "R4 ext0 disabled");
        wr(3'd0, 8'h9F);
        bnd(1'b0, 1'b0, 16'h0, "R9 after write");
        bnd(1'b0, 1'b1, 16'h0003, "R1 edge kept while disabled");
        bnd(1'b1, 1'b0, 16'h0, "R9 reti");

        // R4 register 1 bit 1 enables source 6
        wr(3'd1, 8'h3C);
        bnd(1'b0, 1'b0, 16'h0, "R9 settle");
        strobe(11'h040); strobe('0);
        bnd(1'b0, 1'b0, 16'h0, "R4 src6 disabled");
        wr(3'd1, 8'h3E);
        bnd(1'b0, 1'b0, 16'h0, "R9 after write");
        bnd(1'b0, 1'b1, 16'h0033, "R4 src6 enabled");
        bnd(1'b1, 1'b0, 16'h0, "R9 reti");

        // R4 register 2 bit 0 enables source 5
        wr(3'd2, 8'h00);
        bnd(1'b0, 1'b0, 16'h0, "R9 settle");
        strobe(11'h020);
        bnd(1'b0, 1'b0, 16'h0, "R4 src5 disabled");
        wr(3'd2, 8'h01);
        bnd(1'b0, 1'b0, 16'h0, "R9 after write");
        bnd(1'b0, 1'b1, 16'h002B, "R4 src5 enabled");
        strobe('0);
        bnd(1'b1, 1'b0, 16'h0, "R9 reti");

        // R6/R11 source 5 (group 5) at level 3 beats source 1 at level 0
        wr(3'd3, 8'h20); wr(3'd4, 8'h20);
        bnd(1'b0, 1'b0, 16'h0, "R9 settle");
        strobe(11'h022);
        bnd(1'b0, 1'b1, 16'h002B, "R6 higher level wins");
        bnd(1'b0, 1'b0, 16'h0, "R7 lower level held");
        strobe(11'h002);
        bnd(1'b1, 1'b0, 16'h0, "R9 reti pending lower");
        bnd(1'b0, 1'b1, 16'h000B, "R8 released, lower served");
        // R7 source 3 (group 3) at level 1 nests over level 0
        wr(3'd3, 8'h28);
        bnd(1'b0, 1'b0, 16'h0, "R7 same level held");
        strobe(11'h00A);
        bnd(1'b0, 1'b1, 16'h001B, "R7 nest higher");
        strobe(11'h012);
        bnd(1'b1, 1'b0, 16'h0, "R9 reti");
        bnd(1'b0, 1'b0, 16'h0, "R8 level 0 still active");
        strobe(11'h010);
        bnd(1'b1, 1'b0, 16'h0, "R9 reti");
        bnd(1'b0, 1'b1, 16'h0023, "R8 all released");
        strobe('0);
        bnd(1'b1, 1'b0, 16'h0, "R9 reti");

        // R11 sources 1 and 7 share group 1: tie at level 2 -> lower index
        wr(3'd3, 8'h00); wr(3'd4, 8'h02);
        bnd(1'b0, 1'b0, 16'h0, "R9 settle");
        strobe(11'h082);
        bnd(1'b0, 1'b1, 16'h000B, "R11 tie lowest index");
        strobe(11'h080);
        bnd(1'b1, 1'b0, 16'h0, "R9 reti");
        bnd(1'b0, 1'b1, 16'h003B, "R11 group 1 partner");
        bnd(1'b1, 1'b0, 16'h0, "R9 reti");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule